// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that completes each instruction in one clock cycle. Within that cycle the instruction word is fetched from a dedicated instruction port, decoded, its operands read from a 32-entry register file, the ALU result formed, the data port used by loads and stores, and the result written back on the closing rising edge. The supported set is register add, subtract, AND, OR and signed set-less-than, set-less-than with an immediate, word load, word store and branch-if-equal.

The core is meant to sit between two memories that answer combinationally, one for instructions and one for data. The program counter is the only architectural state outside the register file. A synchronous reset returns the program counter to zero. Any opcode or function code outside the supported set behaves as a no-op.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge the program counter (`imem_addr`) becomes 0; otherwise, unless a branch is taken, it becomes its old value plus 4.
- R2: Instruction fields sit at opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0]. Opcode 0 with funct 0x20 (add), 0x22 (subtract), 0x24 (AND) or 0x25 (OR) writes the result of rs op rt into rd.
- R3: Opcode 0 with funct 0x2A writes 1 into rd when rs is less than rt as signed numbers, else 0; opcode 0x0A writes into rt the same compare of rs against the sign-extended immediate.
- R4: Opcode 0x23 drives `dmem_addr` with rs plus the sign-extended immediate and writes `dmem_rdata` into rt.
- R5: Opcode 0x2B raises `dmem_we` for that cycle with `dmem_addr` equal to rs plus the sign-extended immediate and `dmem_wdata` equal to rt, and writes no register.
- R6: Opcode 0x04 compares rs and rt by subtraction; when equal, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2, otherwise PC+4. It writes no register and no memory.
- R7: Register 0 always reads as 0; writes addressed to it are discarded.
- R8: `dmem_we` is low for every instruction other than a store, including opcodes and function codes outside the set above, which change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to execute (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The properties rely on both memories answering in the same cycle as the address and on `rst` being held high across the first clock edge, so that the program counter is defined before any next-PC property is evaluated. The bench keeps within this by modelling both memories as combinational arrays and asserting reset from time zero. Its program uses only word-aligned addresses and encodings from the listed set plus one deliberate unknown opcode, and it observes register contents only by storing them to data memory, where a scoreboard matches every store against the expected address and value.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_SLTI  = 6'h0A;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    src_imm;
    logic    wb_mem;
    logic    mem_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.rf_we  = 1'b0;
        endcase
      end
      OP_SLTI: begin
        ctl.rf_we   = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.alu_op  = ALU_SLT;
      end
      OP_LW: begin
        ctl.rf_we   = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

  // R3
  slt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_SLT) |-> (y[DW-1:1] == '0));
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  assign rdata_a = (ra == '0) ? '0 : mem[ra];
  assign rdata_b = (rb == '0) ? '0 : mem[rb];

  // R2
  wr_land_chk: assert property (@(posedge clk) disable iff (rst)
    (we && (wa != '0)) |=> (mem[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] imem_addr,
  input  logic [DW-1:0] imem_rdata,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [DW-1:0] dmem_rdata
);
  localparam int            AW   = $clog2(NREGS);
  localparam int            IMMW = 16;
  localparam logic [DW-1:0] STEP = DW'(4);

  logic [DW-1:0] pc, pc_plus4, br_tgt, pc_next;
  logic [DW-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [AW-1:0] rs_a, rt_a, rd_a, wr_a;
  logic          alu_zero, taken;
  ctrl_t         ctl;

  // Phase 1: fetch
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end
  assign imem_addr = pc;
  assign pc_plus4  = pc + STEP;

  // Phase 2: decode and operand read
  assign rs_a    = imem_rdata[21 +: AW];
  assign rt_a    = imem_rdata[16 +: AW];
  assign rd_a    = imem_rdata[11 +: AW];
  assign imm_ext = {{(DW-IMMW){imem_rdata[IMMW-1]}}, imem_rdata[IMMW-1:0]};

  sc_ctrl u_ctrl (
    .opcode (imem_rdata[31:26]),
    .funct  (imem_rdata[5:0]),
    .ctl    (ctl)
  );

  sc_regfile #(.DW(DW), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra      (rs_a),
    .rb      (rt_a),
    .rdata_a (rs_val),
    .rdata_b (rt_val),
    .we      (ctl.rf_we),
    .wa      (wr_a),
    .wd      (wb_val)
  );

  // Phase 3: execute
  assign alu_b = ctl.src_imm ? imm_ext : rt_val;

  sc_alu #(.DW(DW)) u_alu (
    .clk  (clk),
    .rst  (rst),
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign taken   = ctl.branch & alu_zero;
  assign br_tgt  = pc_plus4 + (imm_ext << 2);
  assign pc_next = taken ? br_tgt : pc_plus4;

  // Phase 4: memory
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we;

  // Phase 5: writeback
  assign wr_a   = ctl.dst_rd ? rd_a : rt_a;
  assign wb_val = ctl.wb_mem ? dmem_rdata : alu_y;

  // R1
  pc_reset_chk: assert property (@(posedge clk)
    rst |=> (pc == '0));

  // R1
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc == $past(pc) + STEP));

  // R6
  br_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    taken |=> (pc == $past(pc) + STEP + ($past(imm_ext) << 2)));

  // R5
  st_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !ctl.rf_we);
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  localparam int DW    = 32;
  localparam int WORDS = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic          dmem_we;

  logic [DW-1:0] imem [WORDS];
  logic [DW-1:0] dmem [WORDS];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [DW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } st_item_t;
  st_item_t exp_q [$];

  always #2.5 clk = ~clk;

  sc_core u_sc_core (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_store(logic [DW-1:0] a, logic [DW-1:0] d, string req);
    st_item_t it;
    it.addr = a; it.data = d; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: every store is compared with the next expected item
  always @(negedge clk) begin
    if (!rst && dmem_we && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected store", dmem_addr, '0);
      end else begin
        st_item_t it;
        it = exp_q.pop_front();
        check(dmem_addr == it.addr, {it.req, " addr"}, dmem_addr, it.addr);
        check(dmem_wdata == it.data, {it.req, " data"}, dmem_wdata, it.data);
      end
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      imem[i] = '0;
      dmem[i] = 32'hDEAD_BEEF;
    end
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'd64;

    imem[0]  = enc_i(6'h23, 0, 1, 0);
    imem[1]  = enc_i(6'h23, 0, 2, 4);
    imem[2]  = enc_i(6'h23, 0, 11, 8);
    imem[3]  = enc_r(1, 2, 3, 6'h20);
    imem[4]  = enc_r(1, 2, 4, 6'h22);
    imem[5]  = enc_r(1, 2, 5, 6'h24);
    imem[6]  = enc_r(1, 2, 6, 6'h25);
    imem[7]  = enc_r(2, 1, 7, 6'h2A);
    imem[8]  = enc_r(1, 2, 8, 6'h2A);
    imem[9]  = enc_i(6'h0A, 2, 9, -2);
    imem[10] = enc_i(6'h0A, 1, 10, 5);
    imem[11] = enc_r(1, 1, 0, 6'h20);
    imem[12] = enc_i(6'h3F, 0, 1, 16'h1234);
    imem[13] = enc_i(6'h2B, 0, 3, 16);
    imem[14] = enc_i(6'h2B, 0, 4, 20);
    imem[15] = enc_i(6'h2B, 0, 5, 24);
    imem[16] = enc_i(6'h2B, 0, 6, 28);
    imem[17] = enc_i(6'h2B, 0, 7, 32);
    imem[18] = enc_i(6'h2B, 0, 8, 36);
    imem[19] = enc_i(6'h2B, 0, 9, 40);
    imem[20] = enc_i(6'h2B, 0, 10, 44);
    imem[21] = enc_i(6'h2B, 0, 0, 48);
    imem[22] = enc_i(6'h2B, 11, 1, -8);
    imem[23] = enc_i(6'h23, 0, 12, 16);
    imem[24] = enc_i(6'h2B, 0, 12, 68);
    imem[25] = enc_i(6'h04, 1, 2, 5);
    imem[26] = enc_i(6'h04, 3, 3, 1);
    imem[27] = enc_i(6'h2B, 0, 1, 60);
    imem[28] = enc_i(6'h2B, 0, 2, 64);
    imem[29] = enc_i(6'h04, 0, 0, -1);

    push_store(32'd16, 32'd2,          "R2 add");
    push_store(32'd20, 32'd8,          "R2 sub");
    push_store(32'd24, 32'd5,          "R2 and");
    push_store(32'd28, 32'hFFFF_FFFD,  "R2 or");
    push_store(32'd32, 32'd1,          "R3 slt true");
    push_store(32'd36, 32'd0,          "R3 slt false");
    push_store(32'd40, 32'd1,          "R3 slti negative imm");
    push_store(32'd44, 32'd0,          "R3 slti equal");
    push_store(32'd48, 32'd0,          "R7 r0 after write");
    push_store(32'd56, 32'd5,          "R5 negative offset / R8 unknown op");
    push_store(32'd68, 32'd2,          "R4 load after store");
    push_store(32'd64, 32'hFFFF_FFFD,  "R6 taken branch target");

    repeat (2) @(negedge clk);
    check(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(imem_addr == 32'd4, "R1 pc step", imem_addr, 32'd4);
    @(negedge clk);
    check(imem_addr == 32'd8, "R1 pc step", imem_addr, 32'd8);
    repeat (45) @(negedge clk);
    check(imem_addr == 32'd116, "R6 halt loop pc", imem_addr, 32'd116);
    check(exp_q.size() == 0, "R5 all stores seen", 32'(exp_q.size()), 32'd0);
    check(dmem[15] == 32'hDEAD_BEEF, "R6 skipped store", dmem[15], 32'hDEAD_BEEF);
    check(dmem[17] == 32'd2, "R4 load result stored", dmem[17], 32'd2);
    rst = 1'b1;
    @(negedge clk);
    check(imem_addr == 32'd0, "R1 reset mid-run", imem_addr, 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule